// File: doc/BRIEF.md
# NAND Bus Command Front End

This block sits on the device side of a parallel NAND bus and turns raw bus cycles into decoded operations. It runs on a free-running system clock and watches the active-low write strobe. When that strobe rises while chip enable is low, the block takes the 8-bit I/O byte. The two latch-enable lines mark that byte as a command, an address or a data byte.

A small sequencer follows the multi-cycle protocol. A page read (opcode 00h) or a program setup (80h) takes one column byte and then the row bytes. An erase setup (60h) takes row bytes only. A program or erase takes effect only when its confirm opcode (10h or D0h) arrives after a complete setup. For every recognised operation the block raises a one-cycle strobe, gives an operation code, and holds the assembled column and row address. In the program load phase, each data byte advances the column pointer. An external busy flag limits the accepted opcodes to status and reset.

Top module: `nand_cmd_front`

## Requirements
- R1: A bus cycle is taken only on the clock edge where `we_n` is first seen high after being low and `ce_n` is low. At that edge `cle`, `ale` and `io` must be stable. With no such cycle, no output or internal state changes. After `rst_n`, `op_valid`, `err`, `col_addr` and `row_addr` are all zero.
- R2: Command 00h followed by four address cycles loads `col_addr` from the first byte. The next three bytes fill `row_addr` low byte first, and only bit 0 of the third row byte is used. On the fourth address cycle the block strobes `op` = 1 (read).
- R3: Command 80h followed by four address cycles assembles the address in the same way and strobes `op` = 2 (program start). Each later data cycle (`cle` and `ale` both low) adds one to `col_addr`. Data cycles in any other phase are ignored.
- R4: Command 10h strobes `op` = 3 (program confirm) only after a completed 80h setup. Otherwise it sets `err` and strobes nothing.
- R5: Command 60h followed by three address cycles fills `row_addr` low byte first and leaves `col_addr` unchanged. A following D0h strobes `op` = 4 (erase confirm). A D0h without a completed erase setup sets `err`.
- R6: While `busy` is high, only 70h and FFh take effect. Every other command, address or data cycle changes nothing and sets no error.
- R7: Command 70h strobes `op` = 5 (status) and leaves the sequence state and the addresses untouched.
- R8: Command FFh strobes `op` = 6 (reset), returns the sequencer to idle and clears `err`, whatever the current state.
- R9: Command 90h strobes `op` = 7 (identify) and returns to idle. Address cycles after it are ignored.
- R10: Any opcode other than 00h, 80h, 10h, 60h, D0h, 70h, 90h and FFh returns the sequencer to idle and sets `err`. `err` stays set until FFh or `rst_n`.
- R11: Address cycles beyond the expected count leave both addresses unchanged.
- R12: `op_valid` is high for exactly one clock per recognised operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write strobe; its rising edge takes a cycle |
| cle | input | 1 | Marks the byte as a command |
| ale | input | 1 | Marks the byte as an address (when `cle` is low) |
| io | input | 8 | Bus byte |
| busy | input | 1 | Internal operation in progress |
| op_valid | output | 1 | One-cycle operation strobe |
| op | output | 3 | Operation code, valid with `op_valid` |
| col_addr | output | 8 | Column pointer |
| row_addr | output | 17 | Assembled row (page) address |
| err | output | 1 | Sticky protocol error |

## Verification
The embedded properties check every cycle for the following: cycles with no write edge are inert, the busy filter holds, status leaves the sequence alone, reset clears from any state, the error flag stays set, confirm strobes follow the matching setup state, and the strobe lasts one clock. The byte placement of the address under each opcode can only be shown by the bench's scenarios. The same holds for the column advance during program load, for extra address bytes being discarded, and for the setup a busy period drops being gone once busy falls.

// File: rtl/nand_cmd_front.sv
module nand_cmd_front #(
  parameter int COL_W = 8,
  parameter int ROW_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             we_n,
  input  logic             cle,
  input  logic             ale,
  input  logic [7:0]       io,
  input  logic             busy,
  output logic             op_valid,
  output logic [2:0]       op,
  output logic [COL_W-1:0] col_addr,
  output logic [ROW_W-1:0] row_addr,
  output logic             err
);
  localparam int ROW_CYC = (ROW_W + 7) / 8;
  localparam int CW      = $clog2(ROW_CYC + 2);
  localparam logic [CW-1:0] NEED_PG = CW'(ROW_CYC + 1);
  localparam logic [CW-1:0] NEED_ER = CW'(ROW_CYC);

  localparam logic [7:0] C_READ = 8'h00, C_PSET = 8'h80, C_PCNF = 8'h10,
                         C_ESET = 8'h60, C_ECNF = 8'hD0, C_STAT = 8'h70,
                         C_ID   = 8'h90, C_RST  = 8'hFF;

  localparam logic [2:0] OP_NONE = 3'd0, OP_READ = 3'd1, OP_PSTART = 3'd2,
                         OP_PCONF = 3'd3, OP_ECONF = 3'd4, OP_STATUS = 3'd5,
                         OP_RESET = 3'd6, OP_ID = 3'd7;

  typedef enum logic [2:0] {S_IDLE, S_RADDR, S_PADDR, S_EADDR, S_PLOAD, S_EREADY} st_t;

  st_t                     st;
  logic [CW-1:0]           cnt;
  logic [8*ROW_CYC-1:0]    row_q;
  logic [COL_W-1:0]        col_q;
  logic                    err_q;
  logic                    we_q;
  logic                    opv_q;
  logic [2:0]              op_q;

  logic                    wr, is_cmd, is_addr, is_data, pass, in_addr, last_addr;
  logic [CW-1:0]           need, ridx;
  logic [8*ROW_CYC-1:0]    row_nx;

  assign wr      = we_n & ~we_q & ~ce_n;
  assign is_cmd  = cle;
  assign is_addr = ~cle & ale;
  assign is_data = ~cle & ~ale;
  assign pass    = ~busy | (is_cmd & (io == C_STAT || io == C_RST));
  assign in_addr = (st == S_RADDR) || (st == S_PADDR) || (st == S_EADDR);
  assign need    = (st == S_EADDR) ? NEED_ER : NEED_PG;
  assign last_addr = (cnt == need - CW'(1));
  assign ridx    = (st == S_EADDR) ? cnt : cnt - CW'(1);

  always_comb begin
    row_nx = row_q;
    for (int k = 0; k < ROW_CYC; k++)
      if (ridx == CW'(k)) row_nx[8*k +: 8] = io;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q  <= 1'b1;
      st    <= S_IDLE;
      cnt   <= '0;
      row_q <= '0;
      col_q <= '0;
      err_q <= 1'b0;
      opv_q <= 1'b0;
      op_q  <= OP_NONE;
    end else begin
      we_q  <= we_n;
      opv_q <= 1'b0;
      op_q  <= OP_NONE;
      if (wr && pass) begin
        if (is_cmd) begin
          cnt <= '0;
          unique case (io)
            C_READ: st <= S_RADDR;
            C_PSET: st <= S_PADDR;
            C_ESET: st <= S_EADDR;
            C_STAT: begin
              cnt   <= cnt;
              opv_q <= 1'b1;
              op_q  <= OP_STATUS;
            end
            C_RST: begin
              st    <= S_IDLE;
              err_q <= 1'b0;
              opv_q <= 1'b1;
              op_q  <= OP_RESET;
            end
            C_ID: begin
              st    <= S_IDLE;
              opv_q <= 1'b1;
              op_q  <= OP_ID;
            end
            C_PCNF: begin
              st <= S_IDLE;
              if (st == S_PLOAD) begin
                opv_q <= 1'b1;
                op_q  <= OP_PCONF;
              end else err_q <= 1'b1;
            end
            C_ECNF: begin
              st <= S_IDLE;
              if (st == S_EREADY) begin
                opv_q <= 1'b1;
                op_q  <= OP_ECONF;
              end else err_q <= 1'b1;
            end
            default: begin
              st    <= S_IDLE;
              err_q <= 1'b1;
            end
          endcase
        end else if (is_addr && in_addr) begin
          if (st != S_EADDR && cnt == '0) col_q <= COL_W'(io);
          else                            row_q <= row_nx;
          cnt <= cnt + CW'(1);
          if (last_addr) begin
            unique case (st)
              S_RADDR: begin st <= S_IDLE;   opv_q <= 1'b1; op_q <= OP_READ;   end
              S_PADDR: begin st <= S_PLOAD;  opv_q <= 1'b1; op_q <= OP_PSTART; end
              default:       st <= S_EREADY;
            endcase
          end
        end else if (is_data && st == S_PLOAD) begin
          col_q <= col_q + COL_W'(1);
        end
      end
    end
  end

  assign op_valid = opv_q;
  assign op       = op_q;
  assign col_addr = col_q;
  assign row_addr = row_q[ROW_W-1:0];
  assign err      = err_q;

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> !op_valid && $stable(st) && $stable(col_q) && $stable(row_q) && $stable(err_q));

  p_busy_filter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr && busy && !(cle && (io == C_STAT || io == C_RST))
    |=> !op_valid && $stable(st) && $stable(col_q) && $stable(row_q) && $stable(err_q));

  p_status_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr && cle && io == C_STAT
    |=> op_valid && op == OP_STATUS && $stable(st) && $stable(col_q) && $stable(row_q));

  p_reset_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr && cle && io == C_RST |=> op_valid && op == OP_RESET && st == S_IDLE && !err_q);

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !(wr && cle && io == C_RST) |=> err_q);

  p_pconf_after_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == OP_PCONF |-> $past(st) == S_PLOAD);

  p_econf_after_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == OP_ECONF |-> $past(st) == S_EREADY);

  p_single_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid);
endmodule

// File: tb/tb_nand_cmd_front.sv
module tb_nand_cmd_front;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, cle = 1'b0, ale = 1'b0, busy = 1'b0;
  logic [7:0] io = '0;
  logic op_valid, err;
  logic [2:0] op;
  logic [7:0] col_addr;
  logic [16:0] row_addr;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_cmd_front dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .cle(cle), .ale(ale),
    .io(io), .busy(busy), .op_valid(op_valid), .op(op), .col_addr(col_addr),
    .row_addr(row_addr), .err(err)
  );

  typedef struct packed {
    logic c; logic a; logic bs; logic [7:0] b;
    logic ev; logic [2:0] eop; logic eerr; logic [7:0] ecol; logic [16:0] erow;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 45;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,1'b0,8'h00, 1'b0,3'd0,1'b0,8'h00,17'h00000,4'd2},  // R2 read setup
    '{1'b0,1'b1,1'b0,8'h12, 1'b0,3'd0,1'b0,8'h12,17'h00000,4'd2},
    '{1'b0,1'b1,1'b0,8'h34, 1'b0,3'd0,1'b0,8'h12,17'h00034,4'd2},
    '{1'b0,1'b1,1'b0,8'h56, 1'b0,3'd0,1'b0,8'h12,17'h05634,4'd2},
    '{1'b0,1'b1,1'b0,8'h01, 1'b1,3'd1,1'b0,8'h12,17'h15634,4'd2},
    '{1'b0,1'b1,1'b0,8'h77, 1'b0,3'd0,1'b0,8'h12,17'h15634,4'd11}, // R11 extra byte
    '{1'b1,1'b0,1'b0,8'h80, 1'b0,3'd0,1'b0,8'h12,17'h15634,4'd3},  // R3 program setup
    '{1'b0,1'b1,1'b0,8'h00, 1'b0,3'd0,1'b0,8'h00,17'h15634,4'd3},
    '{1'b0,1'b1,1'b0,8'hAA, 1'b0,3'd0,1'b0,8'h00,17'h156AA,4'd3},
    '{1'b0,1'b1,1'b0,8'hBB, 1'b0,3'd0,1'b0,8'h00,17'h1BBAA,4'd3},
    '{1'b0,1'b1,1'b0,8'h00, 1'b1,3'd2,1'b0,8'h00,17'h0BBAA,4'd3},
    '{1'b0,1'b0,1'b0,8'h5A, 1'b0,3'd0,1'b0,8'h01,17'h0BBAA,4'd3},
    '{1'b0,1'b0,1'b0,8'h5B, 1'b0,3'd0,1'b0,8'h02,17'h0BBAA,4'd3},
    '{1'b1,1'b0,1'b0,8'h70, 1'b1,3'd5,1'b0,8'h02,17'h0BBAA,4'd7},  // R7 status mid-load
    '{1'b0,1'b0,1'b0,8'h5C, 1'b0,3'd0,1'b0,8'h03,17'h0BBAA,4'd7},
    '{1'b1,1'b0,1'b0,8'h10, 1'b1,3'd3,1'b0,8'h03,17'h0BBAA,4'd4},  // R4 confirm
    '{1'b0,1'b0,1'b0,8'h11, 1'b0,3'd0,1'b0,8'h03,17'h0BBAA,4'd3},
    '{1'b1,1'b0,1'b0,8'h60, 1'b0,3'd0,1'b0,8'h03,17'h0BBAA,4'd5},  // R5 erase setup
    '{1'b0,1'b1,1'b0,8'h01, 1'b0,3'd0,1'b0,8'h03,17'h0BB01,4'd5},
    '{1'b0,1'b1,1'b0,8'h02, 1'b0,3'd0,1'b0,8'h03,17'h00201,4'd5},
    '{1'b0,1'b1,1'b0,8'h01, 1'b0,3'd0,1'b0,8'h03,17'h10201,4'd5},
    '{1'b0,1'b1,1'b0,8'h44, 1'b0,3'd0,1'b0,8'h03,17'h10201,4'd11},
    '{1'b1,1'b0,1'b0,8'hD0, 1'b1,3'd4,1'b0,8'h03,17'h10201,4'd5},
    '{1'b1,1'b0,1'b1,8'h00, 1'b0,3'd0,1'b0,8'h03,17'h10201,4'd6},  // R6 busy
    '{1'b1,1'b0,1'b1,8'h60, 1'b0,3'd0,1'b0,8'h03,17'h10201,4'd6},
    '{1'b1,1'b0,1'b1,8'h70, 1'b1,3'd5,1'b0,8'h03,17'h10201,4'd6},
    '{1'b1,1'b0,1'b1,8'h10, 1'b0,3'd0,1'b0,8'h03,17'h10201,4'd6},
    '{1'b0,1'b1,1'b0,8'h07, 1'b0,3'd0,1'b0,8'h03,17'h10201,4'd6},
    '{1'b1,1'b0,1'b0,8'hD0, 1'b0,3'd0,1'b1,8'h03,17'h10201,4'd5},
    '{1'b1,1'b0,1'b0,8'h90, 1'b1,3'd7,1'b1,8'h03,17'h10201,4'd9},  // R9 identify
    '{1'b0,1'b1,1'b0,8'h00, 1'b0,3'd0,1'b1,8'h03,17'h10201,4'd9},
    '{1'b1,1'b0,1'b0,8'hFF, 1'b1,3'd6,1'b0,8'h03,17'h10201,4'd8},  // R8 reset
    '{1'b1,1'b0,1'b0,8'h60, 1'b0,3'd0,1'b0,8'h03,17'h10201,4'd8},
    '{1'b0,1'b1,1'b0,8'h05, 1'b0,3'd0,1'b0,8'h03,17'h10205,4'd8},
    '{1'b1,1'b0,1'b0,8'hFF, 1'b1,3'd6,1'b0,8'h03,17'h10205,4'd8},
    '{1'b1,1'b0,1'b0,8'hD0, 1'b0,3'd0,1'b1,8'h03,17'h10205,4'd8},
    '{1'b1,1'b0,1'b0,8'hFF, 1'b1,3'd6,1'b0,8'h03,17'h10205,4'd8},
    '{1'b1,1'b0,1'b0,8'h3C, 1'b0,3'd0,1'b1,8'h03,17'h10205,4'd10}, // R10 unknown opcode
    '{1'b1,1'b0,1'b0,8'h00, 1'b0,3'd0,1'b1,8'h03,17'h10205,4'd10},
    '{1'b0,1'b1,1'b0,8'h21, 1'b0,3'd0,1'b1,8'h21,17'h10205,4'd10},
    '{1'b1,1'b0,1'b0,8'hFF, 1'b1,3'd6,1'b0,8'h21,17'h10205,4'd8},
    '{1'b1,1'b0,1'b0,8'h80, 1'b0,3'd0,1'b0,8'h21,17'h10205,4'd3},
    '{1'b0,1'b1,1'b0,8'h09, 1'b0,3'd0,1'b0,8'h09,17'h10205,4'd3},
    '{1'b1,1'b0,1'b0,8'h10, 1'b0,3'd0,1'b1,8'h09,17'h10205,4'd4},  // R4 early confirm
    '{1'b0,1'b0,1'b0,8'h33, 1'b0,3'd0,1'b1,8'h09,17'h10205,4'd10}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic bus(input logic c, input logic a, input logic bs, input logic [7:0] b,
                     input logic chip_n);
    @(negedge clk);
    ce_n = chip_n; cle = c; ale = a; busy = bs; io = b; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_state(input string req, input logic ev, input logic [2:0] eop,
                             input logic eerr, input logic [7:0] ecol, input logic [16:0] erow);
    check(req, {op_valid, op, err, col_addr, row_addr}, {ev, eop, eerr, ecol, erow});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_state("R1 reset state", 1'b0, 3'd0, 1'b0, 8'h00, 17'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      bus(TBL[i].c, TBL[i].a, TBL[i].bs, TBL[i].b, 1'b0);
      check_state($sformatf("R%0d vec %0d", TBL[i].rq, i), TBL[i].ev, TBL[i].eop,
                  TBL[i].eerr, TBL[i].ecol, TBL[i].erow);
    end

    // R1: chip not selected, reset opcode must not clear err
    bus(1'b1, 1'b0, 1'b0, 8'hFF, 1'b1);
    check_state("R1 ce_n high", 1'b0, 3'd0, 1'b1, 8'h09, 17'h10205);

    // R1: no write edge, lines change
    @(negedge clk);
    ce_n = 1'b0; cle = 1'b1; io = 8'hFF;
    repeat (3) @(negedge clk);
    check_state("R1 no edge", 1'b0, 3'd0, 1'b1, 8'h09, 17'h10205);

    // R12: strobe lasts one clock
    bus(1'b1, 1'b0, 1'b0, 8'hFF, 1'b0);
    check_state("R12 strobe high", 1'b1, 3'd6, 1'b0, 8'h09, 17'h10205);
    @(negedge clk);
    check("R12 strobe drops", {31'd0, op_valid}, 32'd0);

    // R11: read with a fifth address byte
    bus(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    bus(1'b0, 1'b1, 1'b0, 8'hE1, 1'b0);
    bus(1'b0, 1'b1, 1'b0, 8'h11, 1'b0);
    bus(1'b0, 1'b1, 1'b0, 8'h22, 1'b0);
    bus(1'b0, 1'b1, 1'b0, 8'h03, 1'b0);
    check_state("R2 second read", 1'b1, 3'd1, 1'b0, 8'hE1, 17'h12211);
    bus(1'b0, 1'b1, 1'b0, 8'hF0, 1'b0);
    check_state("R11 fifth byte", 1'b0, 3'd0, 1'b0, 8'hE1, 17'h12211);

    // R1: synchronous reset mid-run
    bus(1'b1, 1'b0, 1'b0, 8'h3C, 1'b0);
    check("R10 err set", {31'd0, err}, 32'd1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_state("R1 reset mid-run", 1'b0, 3'd0, 1'b0, 8'h00, 17'h0);
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule